// File: doc/BRIEF.md
# Operand Shifter with Carry-Out

This block is a purely combinational shifter that prepares the second operand of an ALU. It takes a data word, a two-bit shift kind, a five-bit shift distance and the current carry flag. It returns the shifted word and the carry-out that a logical-class ALU operation may latch into the flags. The result and carry are valid in the same cycle the inputs are applied. No register sits on the path, so there is no valid/ready handshake and no back-pressure to manage.

A distance of zero is not a no-op for every kind. It selects a different operation for each kind:

- Left shift: the word passes through unchanged.
- Logical right and arithmetic right: the shift is by the full word width.
- Rotate: the word rotates by one place through the carry flag.

These re-encodings are the only way to express a full-width shift or a carry rotation when the distance field is five bits wide.

Internally the word passes through a logarithmic chain of rotate stages, one per distance bit. A bit mask then clears or sign-fills the positions vacated by the shift. The carry is picked from the original operand by a separate index mux.

Top module: `shf_barrel`

## Requirements
- R1: Kind code 0 (left shift) with distance 0 returns the operand unchanged, and the carry-out equals the incoming carry.
- R2: Kind 0 with distance n in 1..W-1 shifts toward the top and fills the low n bits with zeros. The carry-out is operand bit W-n.
- R3: Kind code 1 (logical right) with distance 0 shifts by W. The result is all zeros and the carry-out is operand bit W-1.
- R4: Kind 1 with distance n in 1..W-1 zero-fills the top n bits. The carry-out is operand bit n-1.
- R5: Kind code 2 (arithmetic right) with distance 0 gives every result bit equal to operand bit W-1, and the carry-out equals that bit too.
- R6: Kind 2 with distance n in 1..W-1 fills the top n bits with operand bit W-1. The carry-out is operand bit n-1.
- R7: Kind code 3 (rotate) with distance 0 rotates by one place through carry. The result is {carry_i, operand[W-1:1]} and the carry-out is operand bit 0.
- R8: Kind 3 with distance n in 1..W-1 rotates right by n places. The carry-out is operand bit n-1, which equals result bit W-1.
- R9: Result and carry-out settle in the same cycle as the inputs, with no clock or storage in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | W | Word to shift |
| kind_i | input | 2 | Shift kind: 0 left, 1 logical right, 2 arithmetic right, 3 rotate |
| amt_i | input | log2(W) | Shift distance; 0 selects the per-kind special case |
| carry_i | input | 1 | Current carry flag |
| result_o | output | W | Shifted word |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The bench builds the block with its default width of 32, which makes the distance five bits wide. At that size every combination of kind and distance (4 × 32) can be swept exhaustively.

Each kind and distance is applied with both carry values. It is applied to edge words (zero, all ones, lone top bit, lone bottom bit, alternating patterns) and to pseudo-random words. This puts every special zero-distance encoding and both ends of each carry index within reach.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    SHK_LEFT  = 2'd0,
    SHK_LRIGHT = 2'd1,
    SHK_ARIGHT = 2'd2,
    SHK_ROT   = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/shf_rot_stage.sv
module shf_rot_stage #(
  parameter int unsigned W    = 32,
  parameter int unsigned STEP = 1
) (
  input  logic [W-1:0] d_i,
  input  logic         en_i,
  output logic [W-1:0] q_o
);
  // rotate right by STEP places when enabled
  assign q_o = en_i ? {d_i[STEP-1:0], d_i[W-1:STEP]} : d_i;
endmodule

// File: rtl/shf_fill_mask.sv
module shf_fill_mask #(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = $clog2(W)
) (
  input  logic [AW-1:0] amt_i,
  input  logic          left_i,
  output logic [W-1:0]  keep_o
);
  localparam int unsigned XW = AW + 2;
  localparam logic [XW-1:0] WIDTH_X = XW'(W);

  logic [XW-1:0] amt_x;
  assign amt_x = {2'b00, amt_i};

  // keep_o[i] is set where the shifted word carries a real operand bit
  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam logic [XW-1:0] IDX = XW'(i);
    assign keep_o[i] = left_i ? (IDX >= amt_x) : ((amt_x + IDX) < WIDTH_X);
  end
endmodule

// File: rtl/shf_carry_pick.sv
module shf_carry_pick
  import shf_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = $clog2(W)
) (
  input  logic [W-1:0]  operand_i,
  input  shift_kind_e   kind_i,
  input  logic [AW-1:0] amt_i,
  input  logic          carry_i,
  output logic          carry_o
);
  logic          zero_amt;
  logic [AW-1:0] idx_left;
  logic [AW-1:0] idx_right;

  assign zero_amt  = (amt_i == '0);
  assign idx_left  = ~amt_i + 1'b1;  // W - n, modulo W
  assign idx_right = amt_i - 1'b1;   // n - 1

  always_comb begin
    unique case (kind_i)
      SHK_LEFT:   carry_o = zero_amt ? carry_i        : operand_i[idx_left];
      SHK_LRIGHT,
      SHK_ARIGHT: carry_o = zero_amt ? operand_i[W-1] : operand_i[idx_right];
      default:    carry_o = zero_amt ? operand_i[0]   : operand_i[idx_right];
    endcase
  end
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel
  import shf_pkg::*;
#(
  parameter int unsigned W = 32,
  localparam int unsigned AW = $clog2(W)
) (
  input  logic [W-1:0]  operand_i,
  input  logic [1:0]    kind_i,
  input  logic [AW-1:0] amt_i,
  input  logic          carry_i,
  output logic [W-1:0]  result_o,
  output logic          carry_o
);
  shift_kind_e   kind;
  logic          zero_amt;
  logic          is_left;
  logic          sign_bit;
  logic [AW-1:0] rot_amt;
  logic [W-1:0]  keep;
  logic [W-1:0]  rotated;
  logic [W-1:0]  chain [AW+1];

  assign kind     = shift_kind_e'(kind_i);
  assign zero_amt = (amt_i == '0);
  assign is_left  = (kind == SHK_LEFT);
  assign sign_bit = operand_i[W-1];
  // a left shift by n is a right rotate by W - n followed by masking
  assign rot_amt  = is_left ? (~amt_i + 1'b1) : amt_i;

  assign chain[0] = operand_i;
  for (genvar k = 0; k < AW; k++) begin : g_stage
    shf_rot_stage #(.W(W), .STEP(1 << k)) u_stage (
      .d_i (chain[k]),
      .en_i(rot_amt[k]),
      .q_o (chain[k+1])
    );
  end
  assign rotated = chain[AW];

  shf_fill_mask #(.W(W), .AW(AW)) u_mask (
    .amt_i (amt_i),
    .left_i(is_left),
    .keep_o(keep)
  );

  shf_carry_pick #(.W(W), .AW(AW)) u_carry (
    .operand_i(operand_i),
    .kind_i   (kind),
    .amt_i    (amt_i),
    .carry_i  (carry_i),
    .carry_o  (carry_o)
  );

  always_comb begin
    unique case (kind)
      SHK_LEFT:   result_o = rotated & keep;
      SHK_LRIGHT: result_o = zero_amt ? '0 : (rotated & keep);
      SHK_ARIGHT: result_o = zero_amt ? {W{sign_bit}}
                                      : ((rotated & keep) | ({W{sign_bit}} & ~keep));
      default:    result_o = zero_amt ? {carry_i, operand_i[W-1:1]} : rotated;
    endcase
  end

  // checks on the assembled outputs against the inputs
  always_comb begin
    if (kind == SHK_LEFT && zero_amt) begin
      assert_left_zero_pass_R1: assert (result_o == operand_i && carry_o == carry_i);
    end
    if (kind == SHK_LRIGHT && zero_amt) begin
      assert_lright_full_R3: assert (result_o == '0 && carry_o == operand_i[W-1]);
    end
    if (kind == SHK_LRIGHT && !zero_amt) begin
      assert_lright_topzero_R4: assert (result_o[W-1] == 1'b0);
    end
    if (kind == SHK_ARIGHT && zero_amt) begin
      assert_aright_fill_R5: assert (result_o == {W{sign_bit}} && carry_o == sign_bit);
    end
    if (kind == SHK_ARIGHT) begin
      assert_aright_sign_R6: assert (result_o[W-1] == sign_bit);
    end
    if (kind == SHK_ROT && zero_amt) begin
      assert_rot_carry_R7: assert (carry_o == operand_i[0] && result_o[W-1] == carry_i);
    end
    if (kind == SHK_ROT && !zero_amt) begin
      assert_rot_wrapbit_R8: assert (carry_o == result_o[W-1]);
    end
  end
endmodule

// File: tb/shf_barrel_tb_top.sv
module shf_barrel_tb_top;
  localparam int W  = 32;
  localparam int AW = 5;

  typedef struct {
    logic [W-1:0] op;
    logic [1:0]   kind;
    int           amt;
    logic         cin;
    logic [W-1:0] exp_res;
    logic         exp_c;
    int           req;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  operand;
  logic [1:0]    kind;
  logic [AW-1:0] amt;
  logic          cin;
  logic [W-1:0]  result;
  logic          cout;

  int total = 0;
  int bad = 0;
  bit driver_done = 1'b0;
  item_t sb_q[$];

  always #5 clk = ~clk;

  shf_barrel #(.W(W)) dut_i (
    .operand_i(operand),
    .kind_i   (kind),
    .amt_i    (amt),
    .carry_i  (cin),
    .result_o (result),
    .carry_o  (cout)
  );

  // independent reference model
  function automatic item_t model(logic [W-1:0] a, logic [1:0] k, int n, logic c);
    item_t it;
    it.op = a; it.kind = k; it.amt = n; it.cin = c;
    case (k)
      2'd0: begin
        if (n == 0) begin it.exp_res = a; it.exp_c = c; it.req = 1; end        // R1
        else begin it.exp_res = a << n; it.exp_c = a[W-n]; it.req = 2; end      // R2
      end
      2'd1: begin
        if (n == 0) begin it.exp_res = '0; it.exp_c = a[W-1]; it.req = 3; end   // R3
        else begin it.exp_res = a >> n; it.exp_c = a[n-1]; it.req = 4; end      // R4
      end
      2'd2: begin
        if (n == 0) begin it.exp_res = {W{a[W-1]}}; it.exp_c = a[W-1]; it.req = 5; end // R5
        else begin
          it.exp_res = $unsigned($signed(a) >>> n); it.exp_c = a[n-1]; it.req = 6;      // R6
        end
      end
      default: begin
        if (n == 0) begin it.exp_res = {c, a[W-1:1]}; it.exp_c = a[0]; it.req = 7; end // R7
        else begin
          it.exp_res = (a >> n) | (a << (W - n)); it.exp_c = a[n-1]; it.req = 8;        // R8
        end
      end
    endcase
    return it;
  endfunction

  // driver: apply a vector just after a rising edge and queue its expectation
  task automatic drive(logic [W-1:0] a, logic [1:0] k, int n, logic c);
    @(posedge clk);
    operand <= a;
    kind    <= k;
    amt     <= AW'(n);
    cin     <= c;
    sb_q.push_back(model(a, k, n, c));
  endtask

  // monitor: R9, outputs are read half a cycle after the inputs change
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        total++;
        if (result !== it.exp_res || cout !== it.exp_c) begin
          bad++;
          $display("FAIL R%0d (R9 same cycle) kind=%0d amt=%0d op=%h cin=%0b: got res=%h c=%0b, exp res=%h c=%0b",
                   it.req, it.kind, it.amt, it.op, it.cin, result, cout, it.exp_res, it.exp_c);
        end
      end
    end
  end

  initial begin
    logic [W-1:0] pats [16];
    logic [W-1:0] lfsr;
    operand = '0; kind = '0; amt = '0; cin = 1'b0;
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'h8000_0000; pats[3] = 32'h0000_0001;
    pats[4] = 32'hA5A5_3C3C; pats[5] = 32'h5A5A_C3C3;
    pats[6] = 32'h7FFF_FFFF; pats[7] = 32'h8000_0001;
    lfsr = 32'h1234_5679;
    for (int p = 8; p < 16; p++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = lfsr * 32'd1103515245 + 32'd12345;
      pats[p] = lfsr;
    end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    for (int p = 0; p < 16; p++) begin
      for (int k = 0; k < 4; k++) begin
        for (int n = 0; n < W; n++) begin
          for (int c = 0; c < 2; c++) begin
            drive(pats[p], 2'(k), n, c[0]);
          end
        end
      end
    end
    repeat (3) @(posedge clk);
    driver_done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!driver_done) begin
      total++;
      bad++;
      $display("FAIL R9 watchdog expired: got timeout, exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule